// File: doc/BRIEF.md
# Short Relative Branch Resolver

This block works out where the program counter goes next for the four short-format control-flow operations: plain jump, call, jump when a data value is zero, and jump when it is not zero. It receives the current PC, a 3-bit class code, an 8-bit halfword displacement, a flag giving the length of the encoding, and the value of the implicit data register that the conditional forms test. It returns the next PC, a taken flag, a strobe that asks the context unit to save the upper context, the return address for that unit, and a flag for a class code it does not know.

A request enters on a valid/ready handshake, and the result leaves on another. A request is accepted on a clock edge where `in_valid` and `in_ready` are both high. A result is consumed on an edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the result stays on the outputs without change. With `REG_OUT` = 1, one register stage holds a result, and `in_ready` is high whenever that stage is empty or is being drained in the same cycle. With `REG_OUT` = 0, the block is a wire path: `out_valid` follows `in_valid` and `in_ready` follows `out_ready`.

Top module: `sbr_resolver`

## Requirements
- R1: For a taken branch, the 8-bit displacement is sign-extended from its bit 7, doubled, and added to the PC. So 0x7F gives +254 and 0x80 gives -256.
- R2: Class 2 (jump-if-zero) is taken exactly when the tested register equals zero.
- R3: Class 3 (jump-if-nonzero) is taken exactly when the tested register is not zero.
- R4: A branch that is not taken continues at PC + size. The size is 2 when `in_long` = 0 and 4 when `in_long` = 1.
- R5: Class 0 (jump) and class 1 (call) are always taken.
- R6: `out_call_req` is high only for class 1. `out_ret_addr` always equals PC + size.
- R7: Class codes 4 to 7 raise `out_illegal`. For these codes, `out_next_pc` equals the PC, and `out_taken` and `out_call_req` stay low. `out_illegal` is low for codes 0 to 3.
- R8: All PC sums wrap modulo 2^32.
- R9: With `REG_OUT` = 1:
  - A result appears on the outputs one cycle after its request is accepted.
  - While `out_ready` is low, the result is held valid and unchanged.
  - `in_ready` is high exactly when the stage is empty or `out_ready` is high.
- R10: With `REG_OUT` = 0:
  - `out_valid` equals `in_valid`, and `in_ready` equals `out_ready`.
  - The result fields reflect the current inputs in the same cycle.
- R11: While reset is asserted, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| in_pc | input | 32 | Current PC |
| in_cls | input | 3 | Class code: 0 jump, 1 call, 2 jump-if-zero, 3 jump-if-nonzero |
| in_disp | input | 8 | Signed displacement, in halfwords |
| in_long | input | 1 | Encoding length: 0 gives 2 bytes, 1 gives 4 bytes |
| in_d15 | input | 32 | Value of the register the conditional forms test |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream accepts the result |
| out_next_pc | output | 32 | Resolved next PC |
| out_taken | output | 1 | Branch taken |
| out_call_req | output | 1 | Request to save the upper context |
| out_ret_addr | output | 32 | PC + size, for the context unit |
| out_illegal | output | 1 | Unknown class code |

## Verification
The bench builds two copies of the block side by side and drives both with the same stimulus. One copy uses `REG_OUT` = 1, and its one-deep queue model exposes the one-cycle latency, the holding of a result under back-pressure, and the rule for `in_ready`. The other copy uses `REG_OUT` = 0, which lets the bench check every result field against its inputs in the same cycle. Both copies run with 32-bit PCs, so PCs placed near 0 and 0xFFFFFFFE, combined with the extreme displacements, reach the wrap-around of the sums.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  localparam int PC_W   = 32;
  localparam int DISP_W = 8;
  localparam int CLS_W  = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_JMP  = 3'd0,
    CLS_CALL = 3'd1,
    CLS_JZ   = 3'd2,
    CLS_JNZ  = 3'd3
  } cls_e;
endpackage

// File: rtl/sbr_target.sv
module sbr_target #(
  parameter int PC_W   = 32,
  parameter int DISP_W = 8
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [DISP_W-1:0] disp,
  input  logic              is_long,
  output logic [PC_W-1:0]   branch_pc,
  output logic [PC_W-1:0]   seq_pc
);
  localparam int EXT_W = PC_W - DISP_W - 1;

  logic [PC_W-1:0] offset_bytes;

  // sign-extend the halfword count and shift it into bytes
  assign offset_bytes = {{EXT_W{disp[DISP_W-1]}}, disp, 1'b0};
  assign branch_pc    = pc + offset_bytes;
  assign seq_pc       = pc + (is_long ? PC_W'(4) : PC_W'(2));
endmodule

// File: rtl/sbr_cond.sv
module sbr_cond
  import sbr_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic [CLS_W-1:0] cls,
  input  logic [PC_W-1:0]  d15,
  output logic             taken,
  output logic             call_req,
  output logic             illegal
);
  logic is_zero;
  assign is_zero = (d15 == '0);

  always_comb begin
    taken    = 1'b0;
    call_req = 1'b0;
    illegal  = 1'b0;
    case (cls)
      CLS_JMP:  taken = 1'b1;
      CLS_CALL: begin
        taken    = 1'b1;
        call_req = 1'b1;
      end
      CLS_JZ:   taken = is_zero;
      CLS_JNZ:  taken = !is_zero;
      default:  illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/sbr_stage.sv
module sbr_stage #(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  generate
    if (REG_OUT) begin : g_reg
      logic         vld_q;
      logic [W-1:0] dat_q;

      assign in_ready  = !vld_q || out_ready;
      assign out_valid = vld_q;
      assign out_data  = dat_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        vld_q <= 1'b0;
        else if (in_ready) vld_q <= in_valid;
      end

      always_ff @(posedge clk) begin
        if (in_valid && in_ready) dat_q <= in_data;
      end

      AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data)); // R9
      AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid); // R9
    end else begin : g_pass
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_data  = in_data;
    end
  endgenerate
endmodule

// File: rtl/sbr_resolver.sv
module sbr_resolver
  import sbr_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PC_W-1:0]   in_pc,
  input  logic [CLS_W-1:0]  in_cls,
  input  logic [DISP_W-1:0] in_disp,
  input  logic              in_long,
  input  logic [PC_W-1:0]   in_d15,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PC_W-1:0]   out_next_pc,
  output logic              out_taken,
  output logic              out_call_req,
  output logic [PC_W-1:0]   out_ret_addr,
  output logic              out_illegal
);
  localparam int RES_W = 2 * PC_W + 3;

  logic [PC_W-1:0]  branch_pc, seq_pc, next_pc;
  logic             taken, call_req, illegal;
  logic [RES_W-1:0] res_in, res_out;

  sbr_target #(.PC_W(PC_W), .DISP_W(DISP_W)) u_target (
    .pc        (in_pc),
    .disp      (in_disp),
    .is_long   (in_long),
    .branch_pc (branch_pc),
    .seq_pc    (seq_pc)
  );

  sbr_cond #(.PC_W(PC_W)) u_cond (
    .cls      (in_cls),
    .d15      (in_d15),
    .taken    (taken),
    .call_req (call_req),
    .illegal  (illegal)
  );

  always_comb begin
    if (illegal)    next_pc = in_pc;
    else if (taken) next_pc = branch_pc;
    else            next_pc = seq_pc;
  end

  assign res_in = {next_pc, seq_pc, taken, call_req, illegal};

  sbr_stage #(.W(RES_W), .REG_OUT(REG_OUT)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (res_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (res_out)
  );

  assign {out_next_pc, out_ret_addr, out_taken, out_call_req, out_illegal} = res_out;

  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> !out_taken && !out_call_req); // R7
  AST_CALL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_call_req |-> out_taken); // R5
  AST_FALLTHROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_taken && !out_illegal |-> out_next_pc == out_ret_addr); // R4
endmodule

// File: tb/sbr_resolver_tb.sv
module sbr_resolver_tb;
  typedef struct packed {
    logic [31:0] nxt;
    logic [31:0] ret;
    logic        tk;
    logic        cr;
    logic        il;
    logic [2:0]  cls;
    logic        wrap;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0, in_long = 1'b0;
  logic [31:0] in_pc = '0, in_d15 = '0;
  logic [2:0]  in_cls = '0;
  logic [7:0]  in_disp = '0;

  logic        r_in_ready, r_out_valid, r_tk, r_cr, r_il;
  logic [31:0] r_nxt, r_ret;
  logic        c_in_ready, c_out_valid, c_tk, c_cr, c_il;
  logic [31:0] c_nxt, c_ret;

  int checks = 0;
  int errors = 0;
  exp_t q[$];

  always #10 clk = ~clk;

  sbr_resolver #(.REG_OUT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(r_in_ready),
    .in_pc(in_pc), .in_cls(in_cls), .in_disp(in_disp), .in_long(in_long),
    .in_d15(in_d15), .out_valid(r_out_valid), .out_ready(out_ready),
    .out_next_pc(r_nxt), .out_taken(r_tk), .out_call_req(r_cr),
    .out_ret_addr(r_ret), .out_illegal(r_il)
  );

  sbr_resolver #(.REG_OUT(1'b0)) u_comb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(c_in_ready),
    .in_pc(in_pc), .in_cls(in_cls), .in_disp(in_disp), .in_long(in_long),
    .in_d15(in_d15), .out_valid(c_out_valid), .out_ready(out_ready),
    .out_next_pc(c_nxt), .out_taken(c_tk), .out_call_req(c_cr),
    .out_ret_addr(c_ret), .out_illegal(c_il)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic exp_t model();
    exp_t e;
    int   off;
    logic [31:0] seq, tgt;
    off = int'($signed(in_disp)) * 2;
    tgt = in_pc + 32'(off);
    seq = in_pc + (in_long ? 32'd4 : 32'd2);
    e.cls = in_cls;
    e.ret = seq;
    e.il  = (in_cls > 3'd3);
    e.cr  = (in_cls == 3'd1);
    case (in_cls)
      3'd0, 3'd1: e.tk = 1'b1;
      3'd2:       e.tk = (in_d15 == 32'd0);
      3'd3:       e.tk = (in_d15 != 32'd0);
      default:    e.tk = 1'b0;
    endcase
    e.nxt = e.il ? in_pc : (e.tk ? tgt : seq);
    e.wrap = (seq < in_pc) ||
             (e.tk && !e.il && ((off > 0 && tgt < in_pc) || (off < 0 && tgt > in_pc)));
    return e;
  endfunction

  task automatic cmp(input string who, input exp_t e, input logic [31:0] nxt,
                     input logic [31:0] ret, input logic tk, input logic cr, input logic il);
    string tt;
    case (e.cls)
      3'd0, 3'd1: tt = "R5";
      3'd2:       tt = "R2";
      3'd3:       tt = "R3";
      default:    tt = "R7";
    endcase
    chk({who, e.il ? " next_pc R7" : (e.tk ? " target R1" : " fallthrough R4"),
         e.wrap ? " R8" : ""}, nxt, e.nxt);
    chk({who, " taken ", tt}, 32'(tk), 32'(e.tk));
    chk({who, " call_req R6"}, 32'(cr), 32'(e.cr));
    chk({who, e.wrap ? " ret_addr R6 R8" : " ret_addr R6"}, ret, e.ret);
    chk({who, " illegal R7"}, 32'(il), 32'(e.il));
  endtask

  task automatic step(input logic v, input logic rdy, input logic [31:0] pc,
                      input logic [2:0] cls, input logic [7:0] d, input logic lng,
                      input logic [31:0] d15);
    exp_t e;
    @(negedge clk);
    in_valid = v; out_ready = rdy; in_pc = pc; in_cls = cls;
    in_disp = d; in_long = lng; in_d15 = d15;
    #5;
    e = model();
    // registered copy against the one-deep queue model
    chk("reg out_valid R9", 32'(r_out_valid), 32'(q.size() > 0));
    chk("reg in_ready R9", 32'(r_in_ready), 32'(q.size() == 0 || rdy));
    if (q.size() > 0 && r_out_valid) cmp("reg", q[0], r_nxt, r_ret, r_tk, r_cr, r_il);
    // wire-path copy
    chk("comb out_valid R10", 32'(c_out_valid), 32'(v));
    chk("comb in_ready R10", 32'(c_in_ready), 32'(rdy));
    if (v) cmp("comb R10", e, c_nxt, c_ret, c_tk, c_cr, c_il);
    // advance model to the coming edge
    if (q.size() > 0 && rdy) void'(q.pop_front());
    if (v && (q.size() == 0)) q.push_back(e);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) begin
      @(negedge clk);
      chk("reset out_valid R11", 32'(r_out_valid), 32'd0);
    end
    rst_n = 1'b1;
    // R1 / R5 jumps, extreme displacements
    step(1, 1, 32'h0000_1000, 3'd0, 8'h7F, 0, 32'd5);
    step(1, 1, 32'h0000_1000, 3'd0, 8'h80, 0, 32'd5);
    step(1, 1, 32'h0000_1000, 3'd0, 8'hFF, 1, 32'd0);
    // R6 call
    step(1, 1, 32'h0000_2000, 3'd1, 8'h10, 0, 32'd1);
    step(1, 1, 32'h0000_2000, 3'd1, 8'hF0, 1, 32'd1);
    // R2 / R3 conditionals, taken and not, both sizes (R4)
    step(1, 1, 32'h0000_3000, 3'd2, 8'h04, 0, 32'd0);
    step(1, 1, 32'h0000_3000, 3'd2, 8'h04, 0, 32'd9);
    step(1, 1, 32'h0000_3000, 3'd2, 8'h04, 1, 32'h8000_0000);
    step(1, 1, 32'h0000_3000, 3'd3, 8'h04, 0, 32'd0);
    step(1, 1, 32'h0000_3000, 3'd3, 8'h04, 1, 32'd0);
    step(1, 1, 32'h0000_3000, 3'd3, 8'h84, 0, 32'd1);
    // R7 unknown classes
    for (int c = 4; c < 8; c++) step(1, 1, 32'h0000_4000, 3'(c), 8'h22, 0, 32'd0);
    // R8 wrap both ways
    step(1, 1, 32'hFFFF_FFFE, 3'd0, 8'h02, 0, 32'd0);
    step(1, 1, 32'h0000_0002, 3'd0, 8'hFE, 0, 32'd0);
    step(1, 1, 32'hFFFF_FFFE, 3'd3, 8'h02, 1, 32'd0);
    step(1, 1, 32'hFFFF_FFFE, 3'd1, 8'h02, 0, 32'd0);
    // R9 back-pressure hold
    step(1, 0, 32'h0000_5000, 3'd1, 8'h03, 0, 32'd0);
    step(1, 0, 32'h0000_6000, 3'd0, 8'h03, 0, 32'd0);
    step(0, 0, 32'h0000_7000, 3'd2, 8'h03, 0, 32'd0);
    step(0, 1, 32'h0000_7000, 3'd2, 8'h03, 0, 32'd0);
    step(0, 1, 32'h0000_7000, 3'd2, 8'h03, 0, 32'd0);
    // random traffic
    for (int i = 0; i < 400; i++)
      step(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 2) != 0), $urandom(),
           3'($urandom_range(0, 7)), 8'($urandom()), 1'($urandom()),
           ($urandom_range(0, 2) == 0) ? 32'd0 : $urandom());
    step(0, 1, 32'd0, 3'd0, 8'd0, 0, 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule